// File: doc/BRIEF.md
# Cache Maintenance Command Queue

This block sits between a processor bus and the maintenance engine of a cache. Software builds one command through a small set of word registers: first an operation word, then a start address and a byte count when the command covers a range, then a mask of cache ways when the command targets ways. Once the last register that the command needs has been written, the block places the command in a small FIFO. A dispatcher hands commands to the engine one at a time over a valid/ready handshake and waits for a done pulse before it sends the next one.

Software polls a queue status register after each command. That register holds sticky "full" and "overflow" flags, which show that the command was dropped and that the whole register sequence has to be written again. A completion register reads 1 when the engine has finished the last queued command. Writing 1 to it clears it. There is also a sync register. Writing the sync key to it starts a drain. A read of that register is held off until the queue is empty and the engine is idle, so the read acts as a barrier.

Two state machines control the block. The assembler has the states AS_IDLE, AS_RANGE (range parameters pending) and AS_WAYS (way mask pending). Its transitions are:
- An operation word moves it to AS_RANGE, AS_WAYS or AS_IDLE with an immediate push.
- A size write moves it from AS_RANGE to AS_WAYS or to AS_IDLE with a push.
- A way write moves it from AS_WAYS to AS_IDLE with a push.
- Any operation word restarts the sequence from whatever state it is in.

The dispatcher has the states DS_IDLE, DS_ISSUE (valid raised) and DS_WAIT (command accepted, done outstanding). Its transitions are:
- DS_IDLE moves to DS_ISSUE when the queue is not empty.
- DS_ISSUE moves to DS_WAIT on ready.
- DS_WAIT moves to DS_IDLE on done.

Top module: `cmq_top`

## Requirements
- R1: After reset the queue status register (word 4) reads 0, the completion register (word 5) reads 0, eng_valid is low, and a read of the sync register (word 6) is acknowledged in the same cycle.
- R2: The operation word (word 0) has these fields: bit 31 enables the command, bit 8 selects range scope, bit 9 selects way targeting, and bits 3:0 hold the command code (1 flush, 2 invalidate, 3 prefetch, 4 touch, 5 touch-with-zero). An enabled whole-cache command with normal targeting is queued on the operation write itself, and it reaches the engine with start, size and way mask all zero, whatever was written to words 1 to 3.
- R3: A range command is queued only when the size register (word 2) is written. It carries the start address (word 1) and the size written after its operation word.
- R4: A way-targeted command is queued only when the way register (word 3) is written. It carries the low WAY_W bits of that write. If such a command is not range-scoped, its start and size reach the engine as zero. If it is also range-scoped, it needs the size first and then the way mask.
- R5: An operation word with bit 31 clear, or with a code outside 1 to 5, queues nothing and leaves the status flags at 0.
- R6: A command that completes assembly while DEPTH commands are held is dropped and sets queue status bit 0 (full).
- R7: A command dropped while the full flag is already set also sets queue status bit 1 (overflow). An operation-word write that finds a free FIFO slot clears both flags.
- R8: eng_valid stays high with unchanged command fields until eng_ready. Only one command is in flight until eng_done. Commands reach the engine in the order they were queued.
- R9: The completion register reads 1 once eng_done has been seen with the queue empty. Writing 1 to it clears it. Writing any other value leaves it unchanged.
- R10: Writing 1 to the sync register starts a drain. A read of the sync register is then not acknowledged until the queue is empty and no command is in flight. Writing any other value starts no drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access completes in this cycle |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| eng_valid | output | 1 | Command offered to the engine |
| eng_ready | input | 1 | Engine accepts the command |
| eng_code | output | 4 | Command code |
| eng_range | output | 1 | Range scope |
| eng_byway | output | 1 | Way targeting |
| eng_start | output | DATA_W | Start address (zero unless range) |
| eng_size | output | DATA_W | Byte count (zero unless range) |
| eng_ways | output | WAY_W | Way mask (zero unless way-targeted) |
| eng_done | input | 1 | One-cycle pulse when the engine has finished the command |

## Verification
A wrong assembler state shows up at the engine port, usually within a few cycles. It appears as a command dispatched before its last parameter write, as a command that never appears, or as start, size or way fields carrying data they should have ignored. A wrong dispatcher or FIFO state shows up as:
- a reordered or duplicated command,
- valid dropped before ready,
- a completion flag that rises while work is still queued,
- a sync read that returns early or hangs.

Flag errors are visible on the very next status read after the rejected command.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] RG_OP    = 3'd0;
    localparam logic [SEL_W-1:0] RG_START = 3'd1;
    localparam logic [SEL_W-1:0] RG_SIZE  = 3'd2;
    localparam logic [SEL_W-1:0] RG_WAYS  = 3'd3;
    localparam logic [SEL_W-1:0] RG_QSTAT = 3'd4;
    localparam logic [SEL_W-1:0] RG_END   = 3'd5;
    localparam logic [SEL_W-1:0] RG_SYNC  = 3'd6;

    localparam int OPW_EN    = 31;
    localparam int OPW_RANGE = 8;
    localparam int OPW_BYWAY = 9;
    localparam int CODE_W    = 4;

    typedef enum logic [CODE_W-1:0] {
        CMD_FLUSH    = 4'd1,
        CMD_INVAL    = 4'd2,
        CMD_PREFETCH = 4'd3,
        CMD_TOUCH    = 4'd4,
        CMD_TOUCHZ   = 4'd5
    } cmd_code_e;

    localparam logic [31:0] SYNC_KEY = 32'h1;
    localparam logic [31:0] END_MARK = 32'h1;

    typedef enum logic [1:0] {AS_IDLE, AS_RANGE, AS_WAYS} asm_state_e;
    typedef enum logic [1:0] {DS_IDLE, DS_ISSUE, DS_WAIT} dsp_state_e;

    function automatic logic code_known(input logic [CODE_W-1:0] c);
        return (c >= CODE_W'(CMD_FLUSH)) && (c <= CODE_W'(CMD_TOUCHZ));
    endfunction

endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: the assembler must never push into a full queue
    a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R8: the dispatcher pops only a held command
    a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/cmq_assemble.sv
module cmq_assemble
    import cmq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WAY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_op,
    input  logic              wr_start,
    input  logic              wr_size,
    input  logic              wr_ways,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fifo_full,
    output logic              push,
    output logic [CODE_W-1:0] push_code,
    output logic              push_range,
    output logic              push_byway,
    output logic [DATA_W-1:0] push_start,
    output logic [DATA_W-1:0] push_size,
    output logic [WAY_W-1:0]  push_ways,
    output logic              flag_full,
    output logic              flag_ovf
);
    asm_state_e        state, state_nxt;
    logic              attempt, op_go;
    logic [CODE_W-1:0] op_code;
    logic              op_range, op_byway;
    logic [DATA_W-1:0] sh_start, sh_size;
    logic [WAY_W-1:0]  sh_ways;
    logic              cur_range, cur_byway;
    logic [DATA_W-1:0] cur_size;
    logic [WAY_W-1:0]  cur_ways;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= AS_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        op_go     = wr_op && wdata[OPW_EN] && code_known(wdata[CODE_W-1:0]);
        state_nxt = state;
        attempt   = 1'b0;
        if (wr_op) begin
            if (!op_go)                 state_nxt = AS_IDLE;
            else if (wdata[OPW_RANGE])  state_nxt = AS_RANGE;
            else if (wdata[OPW_BYWAY])  state_nxt = AS_WAYS;
            else begin
                state_nxt = AS_IDLE;
                attempt   = 1'b1;
            end
        end else begin
            unique case (state)
                AS_IDLE:  state_nxt = AS_IDLE;
                AS_RANGE: if (wr_size) begin
                    if (op_byway) state_nxt = AS_WAYS;
                    else begin
                        state_nxt = AS_IDLE;
                        attempt   = 1'b1;
                    end
                end
                AS_WAYS: if (wr_ways) begin
                    state_nxt = AS_IDLE;
                    attempt   = 1'b1;
                end
                default: state_nxt = AS_IDLE;
            endcase
        end
    end

    // outputs: command fields, masked by scope and target
    always_comb begin
        push_code  = wr_op ? wdata[CODE_W-1:0] : op_code;
        cur_range  = wr_op ? wdata[OPW_RANGE] : op_range;
        cur_byway  = wr_op ? wdata[OPW_BYWAY] : op_byway;
        cur_size   = wr_size ? wdata : sh_size;
        cur_ways   = wr_ways ? wdata[WAY_W-1:0] : sh_ways;
        push_range = cur_range;
        push_byway = cur_byway;
        push_start = (cur_range && !wr_op) ? sh_start : '0;
        push_size  = (cur_range && !wr_op) ? cur_size : '0;
        push_ways  = (cur_byway && !wr_op) ? cur_ways : '0;
        push       = attempt && !fifo_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_code  <= '0;
            op_range <= 1'b0;
            op_byway <= 1'b0;
            sh_start <= '0;
            sh_size  <= '0;
            sh_ways  <= '0;
        end else if (wr_op) begin
            op_code  <= wdata[CODE_W-1:0];
            op_range <= wdata[OPW_RANGE];
            op_byway <= wdata[OPW_BYWAY];
            sh_start <= '0;
            sh_size  <= '0;
            sh_ways  <= '0;
        end else begin
            if (wr_start) sh_start <= wdata;
            if (wr_size)  sh_size  <= wdata;
            if (wr_ways)  sh_ways  <= wdata[WAY_W-1:0];
        end
    end

    // sticky reject flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_full <= 1'b0;
            flag_ovf  <= 1'b0;
        end else begin
            if (wr_op && !fifo_full) begin
                flag_full <= 1'b0;
                flag_ovf  <= 1'b0;
            end
            if (attempt && fifo_full) begin
                flag_full <= 1'b1;
                if (flag_full) flag_ovf <= 1'b1;
            end
        end
    end

    // R7: overflow is never reported without full
    a_r7_ovf_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ovf |-> flag_full);
    // R6: a rejected command leaves the full flag set
    a_r6_drop_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt && fifo_full) |=> flag_full);
    // R3: no push while range parameters are still pending
    a_r3_range_waits_size: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AS_RANGE && !wr_size && !wr_op) |-> !push);

endmodule

// File: rtl/cmq_dispatch.sv
module cmq_dispatch
    import cmq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    output logic fifo_pop,
    output logic eng_valid,
    input  logic eng_ready,
    input  logic eng_done,
    input  logic end_clr,
    input  logic sync_req,
    output logic sync_pend,
    output logic end_flag
);
    dsp_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DS_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            DS_IDLE:  if (!fifo_empty) state_nxt = DS_ISSUE;
            DS_ISSUE: if (eng_ready)   state_nxt = DS_WAIT;
            DS_WAIT:  if (eng_done)    state_nxt = DS_IDLE;
            default:  state_nxt = DS_IDLE;
        endcase
    end

    always_comb begin
        eng_valid = (state == DS_ISSUE);
        fifo_pop  = eng_valid && eng_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_flag  <= 1'b0;
            sync_pend <= 1'b0;
        end else begin
            if (state == DS_WAIT && eng_done && fifo_empty) end_flag <= 1'b1;
            else if (end_clr)                               end_flag <= 1'b0;
            if (sync_req)                                   sync_pend <= 1'b1;
            else if (fifo_empty && state == DS_IDLE)        sync_pend <= 1'b0;
        end
    end

    // R8: an offered command is not withdrawn before acceptance
    a_r8_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_ready) |=> eng_valid);
    // R9: completion rises only as the result of a done pulse
    a_r9_end_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> $past(eng_done));
    // R10: a drain finishes only with the queue empty
    a_r10_drain_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_pend) |-> $past(fifo_empty));

endmodule

// File: rtl/cmq_top.sv
module cmq_top
    import cmq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WAY_W  = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              eng_valid,
    input  logic              eng_ready,
    output logic [3:0]        eng_code,
    output logic              eng_range,
    output logic              eng_byway,
    output logic [DATA_W-1:0] eng_start,
    output logic [DATA_W-1:0] eng_size,
    output logic [WAY_W-1:0]  eng_ways,
    input  logic              eng_done
);
    localparam int ENTRY_W = CODE_W + 2 + 2 * DATA_W + WAY_W;

    logic              wr, wr_op, wr_start, wr_size, wr_ways;
    logic              sync_req, end_clr, rd_blocked;
    logic              push, pop, fifo_full, fifo_empty;
    logic [CODE_W-1:0] p_code;
    logic              p_range, p_byway;
    logic [DATA_W-1:0] p_start, p_size;
    logic [WAY_W-1:0]  p_ways;
    logic [ENTRY_W-1:0] entry_in, head;
    logic              flag_full, flag_ovf, sync_pend, end_flag;

    always_comb begin
        wr         = bus_req && bus_we;
        wr_op      = wr && (bus_addr == RG_OP);
        wr_start   = wr && (bus_addr == RG_START);
        wr_size    = wr && (bus_addr == RG_SIZE);
        wr_ways    = wr && (bus_addr == RG_WAYS);
        sync_req   = wr && (bus_addr == RG_SYNC) && (bus_wdata == DATA_W'(SYNC_KEY));
        end_clr    = wr && (bus_addr == RG_END)  && (bus_wdata == DATA_W'(END_MARK));
        rd_blocked = bus_req && !bus_we && (bus_addr == RG_SYNC) && sync_pend;
        bus_ack    = bus_req && !rd_blocked;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == RG_QSTAT)    bus_rdata = DATA_W'({flag_ovf, flag_full});
        else if (bus_addr == RG_END) bus_rdata = DATA_W'(end_flag);
    end

    cmq_assemble #(.DATA_W(DATA_W), .WAY_W(WAY_W)) u_asm (
        .clk(clk), .rst_n(rst_n),
        .wr_op(wr_op), .wr_start(wr_start), .wr_size(wr_size), .wr_ways(wr_ways),
        .wdata(bus_wdata), .fifo_full(fifo_full),
        .push(push), .push_code(p_code), .push_range(p_range), .push_byway(p_byway),
        .push_start(p_start), .push_size(p_size), .push_ways(p_ways),
        .flag_full(flag_full), .flag_ovf(flag_ovf)
    );

    assign entry_in = {p_code, p_range, p_byway, p_start, p_size, p_ways};

    cmq_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din(entry_in), .pop(pop), .dout(head),
        .full(fifo_full), .empty(fifo_empty)
    );

    assign {eng_code, eng_range, eng_byway, eng_start, eng_size, eng_ways} = head;

    cmq_dispatch u_dsp (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(fifo_empty), .fifo_pop(pop),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_done(eng_done),
        .end_clr(end_clr), .sync_req(sync_req),
        .sync_pend(sync_pend), .end_flag(end_flag)
    );

    // R8: command fields hold while the engine stalls
    a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_ready) |=> ($stable(eng_code) && $stable(eng_start)
                                       && $stable(eng_size) && $stable(eng_ways)));
    // R10: a held sync read is never acknowledged
    a_r10_sync_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == RG_SYNC && sync_pend) |-> !bus_ack);

endmodule

// File: tb/tb_cmq_top.sv
module tb_cmq_top;
    import cmq_pkg::*;

    localparam int DATA_W = 32;
    localparam int WAY_W  = 8;
    localparam int DEPTH  = 4;
    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] RNG = 32'h0000_0100;
    localparam logic [31:0] BYW = 32'h0000_0200;

    logic              clk, rst_n;
    logic              bus_req, bus_we, bus_ack;
    logic [2:0]        bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;
    logic              eng_valid, eng_ready, eng_range, eng_byway, eng_done;
    logic [3:0]        eng_code;
    logic [DATA_W-1:0] eng_start, eng_size;
    logic [WAY_W-1:0]  eng_ways;

    cmq_top #(.DATA_W(DATA_W), .WAY_W(WAY_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_code(eng_code),
        .eng_range(eng_range), .eng_byway(eng_byway), .eng_start(eng_start),
        .eng_size(eng_size), .eng_ways(eng_ways), .eng_done(eng_done)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_run = 0, n_fail = 0;
    int rec_n = 0;
    bit ready_en = 1'b1;
    logic [3:0]        r_code  [64];
    logic              r_range [64];
    logic              r_byway [64];
    logic [DATA_W-1:0] r_start [64];
    logic [DATA_W-1:0] r_size  [64];
    logic [WAY_W-1:0]  r_ways  [64];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // engine model: accepts when ready_en, pulses done three cycles later
    initial begin
        int done_cnt;
        done_cnt  = 0;
        eng_ready = 1'b0;
        eng_done  = 1'b0;
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (done_cnt > 0) begin
                done_cnt--;
                if (done_cnt == 0) eng_done = 1'b1;
            end
            eng_ready = ready_en;
            #1;
            if (eng_valid && eng_ready && rst_n) begin
                r_code[rec_n]  = eng_code;
                r_range[rec_n] = eng_range;
                r_byway[rec_n] = eng_byway;
                r_start[rec_n] = eng_start;
                r_size[rec_n]  = eng_size;
                r_ways[rec_n]  = eng_ways;
                rec_n++;
                done_cnt = 3;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic bw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic br(input logic [2:0] a, input int maxw,
                      output logic [31:0] d, output int waited);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        waited = 0;
        #1;
        while (!bus_ack && waited < maxw) begin
            @(negedge clk);
            #1;
            waited++;
        end
        d = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    function automatic logic [31:0] rd0(input logic [31:0] v); return v; endfunction

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        int w;
        br(a, 20, d, w);
    endtask

    task automatic settle;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        int w;
        rd(RG_QSTAT, d); chk("R1 qstat after reset", d, 0);
        rd(RG_END, d);   chk("R1 end flag after reset", d, 0);
        chk("R1 eng_valid after reset", eng_valid, 0);
        br(RG_SYNC, 20, d, w); chk("R1 sync read immediate", w, 0);
    endtask

    task automatic t_all_flush;
        logic [31:0] d;
        int base;
        base = rec_n;
        bw(RG_START, 32'hDEAD_0000);
        bw(RG_WAYS, 32'hFF);
        bw(RG_OP, EN | 32'(CMD_FLUSH));
        settle();
        chk("R2 all-scope queued on op write", rec_n, base + 1);
        chk("R2 code", r_code[base], CMD_FLUSH);
        chk("R2 start zero", r_start[base], 0);
        chk("R2 size zero", r_size[base], 0);
        chk("R2 ways zero", r_ways[base], 0);
        rd(RG_END, d); chk("R9 end flag set", d, 1);
        bw(RG_END, 32'h2);
        rd(RG_END, d); chk("R9 non-marker write ignored", d, 1);
        bw(RG_END, 32'h1);
        rd(RG_END, d); chk("R9 marker write clears", d, 0);
    endtask

    task automatic t_range;
        int base;
        base = rec_n;
        bw(RG_OP, EN | RNG | 32'(CMD_INVAL));
        bw(RG_START, 32'h0000_1000);
        settle();
        chk("R3 not queued before size", rec_n, base);
        bw(RG_SIZE, 32'h200);
        settle();
        chk("R3 queued after size", rec_n, base + 1);
        chk("R3 start", r_start[base], 32'h1000);
        chk("R3 size", r_size[base], 32'h200);
        chk("R3 code", r_code[base], CMD_INVAL);
        chk("R3 ways zero", r_ways[base], 0);
    endtask

    task automatic t_byway;
        int base;
        base = rec_n;
        bw(RG_OP, EN | BYW | 32'(CMD_PREFETCH));
        bw(RG_START, 32'h40);
        bw(RG_SIZE, 32'h80);
        settle();
        chk("R4 not queued before ways", rec_n, base);
        bw(RG_WAYS, 32'h15A);
        settle();
        chk("R4 queued after ways", rec_n, base + 1);
        chk("R4 ways low bits", r_ways[base], 8'h5A);
        chk("R4 start ignored", r_start[base], 0);
        chk("R4 size ignored", r_size[base], 0);
        chk("R4 code prefetch", r_code[base], CMD_PREFETCH);
        base = rec_n;
        bw(RG_OP, EN | RNG | BYW | 32'(CMD_TOUCHZ));
        bw(RG_START, 32'h2000);
        bw(RG_SIZE, 32'h40);
        settle();
        chk("R4 range+way waits for ways", rec_n, base);
        bw(RG_WAYS, 32'h03);
        settle();
        chk("R4 range+way queued", rec_n, base + 1);
        chk("R4 range+way start", r_start[base], 32'h2000);
        chk("R4 range+way size", r_size[base], 32'h40);
        chk("R4 range+way ways", r_ways[base], 8'h03);
        chk("R4 range+way code", r_code[base], CMD_TOUCHZ);
    endtask

    task automatic t_reject;
        logic [31:0] d;
        int base;
        base = rec_n;
        bw(RG_OP, EN | 32'h7);
        bw(RG_OP, 32'(CMD_FLUSH));
        bw(RG_OP, EN);
        settle();
        chk("R5 nothing queued", rec_n, base);
        rd(RG_QSTAT, d); chk("R5 flags clear", d, 0);
    endtask

    task automatic t_full;
        logic [31:0] d;
        int base, w;
        bw(RG_END, 32'h1);
        ready_en = 1'b0;
        repeat (3) @(negedge clk);
        base = rec_n;
        bw(RG_OP, EN | 32'(CMD_FLUSH));
        bw(RG_OP, EN | 32'(CMD_INVAL));
        bw(RG_OP, EN | 32'(CMD_FLUSH));
        bw(RG_OP, EN | 32'(CMD_INVAL));
        repeat (3) @(negedge clk);
        chk("R8 valid held while stalled", eng_valid, 1);
        chk("R8 head is first command", eng_code, CMD_FLUSH);
        rd(RG_QSTAT, d); chk("R6 no flag at exactly depth", d, 0);
        bw(RG_OP, EN | 32'(CMD_TOUCH));
        rd(RG_QSTAT, d); chk("R6 full on drop", d, 1);
        bw(RG_OP, EN | 32'(CMD_TOUCH));
        rd(RG_QSTAT, d); chk("R7 overflow on second drop", d, 3);
        chk("R8 valid still held", eng_valid, 1);
        chk("R8 head unchanged", eng_code, CMD_FLUSH);
        rd(RG_END, d); chk("R9 no completion while queued", d, 0);
        bw(RG_SYNC, SYNC_KEY);
        fork
            begin
                repeat (12) @(negedge clk);
                ready_en = 1'b1;
            end
        join_none
        br(RG_SYNC, 500, d, w);
        chk("R10 sync read held during drain", (w >= 10), 1);
        chk("R10 sync read completes", (w < 500), 1);
        chk("R10 all drained at ack", rec_n, base + 4);
        chk("R8 order 0", r_code[base],     CMD_FLUSH);
        chk("R8 order 1", r_code[base + 1], CMD_INVAL);
        chk("R8 order 2", r_code[base + 2], CMD_FLUSH);
        chk("R8 order 3", r_code[base + 3], CMD_INVAL);
        rd(RG_END, d); chk("R9 completion after drain", d, 1);
        bw(RG_OP, EN | 32'(CMD_FLUSH));
        rd(RG_QSTAT, d); chk("R7 op write with room clears flags", d, 0);
        settle();
        chk("R7 clearing command queued", rec_n, base + 5);
    endtask

    task automatic t_sync_key;
        logic [31:0] d;
        int w;
        bw(RG_END, 32'h1);
        ready_en = 1'b0;
        bw(RG_OP, EN | 32'(CMD_FLUSH));
        repeat (3) @(negedge clk);
        bw(RG_SYNC, 32'h2);
        br(RG_SYNC, 50, d, w);
        chk("R10 wrong key starts no drain", w, 0);
        ready_en = 1'b1;
        settle();
        rd(RG_END, d); chk("R9 completion after release", d, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_flush();
        t_range();
        t_byway();
        t_reject();
        t_full();
        t_sync_key();
        summary();
        $finish;
    end

endmodule